// File: doc/BRIEF.md
# Silent Store Pair Predictor

This block watches the store stream of one core and learns which stores are later undone by another store to the same location. The usual case is a lock acquire followed by its release. It keeps a small direct-mapped table indexed by the store's program counter. Each entry holds a partial-PC tag and a 2-bit saturating confidence counter. A store that changes memory can open a pair. The block then records the address and the value that was there before the store. The pair closes when a later store to that address writes the recorded value back.

When a store hits a confident entry and the lock hint says the word is free, the block raises an elide decision. The memory side then holds back that store and the one that restores the value. When the pair closes cleanly the block pulses commit, and both stores are dropped. If a different value is written to the watched word, or the pair stays open too long, the block pulses squash. The held-back store must then be performed, and the entry's confidence is cleared. Only one pair is watched at a time. Register checkpointing and store buffering sit outside this block.

Top module: `ssp_predictor`

## Requirements
- R1: After reset every table entry is invalid and no pair is open. Outputs are low while no store is presented, and the first store seen by any entry is not elided.
- R2: The entry index is PC bits [6:2] and the entry tag is PC bits [12:7]. A PC with the same index but a different tag misses, and a validated pair from it replaces the entry.
- R3: An open pair validates when a later store to the same address writes the value that was present before the opening store. Validation raises the entry's 2-bit confidence by one; a pair that allocates a new entry gives it confidence 1.
- R4: `elide_o` rises for a store exactly when no pair is open, the entry hits with confidence of 2 or more, the store changes the value (new differs from old), and `lock_held_i` is low. `pair_tag_o` then carries the entry index. So an unseen pair is tracked twice and elided on its third occurrence.
- R5: With `lock_held_i` high no elision is started, but the pair is still opened for training, and its validation still counts.
- R6: When an elided pair validates, `commit_o` pulses in the cycle of the restoring store, with `pair_tag_o` equal to the entry index. `commit_o` and `squash_o` never rise together.
- R7: A store to the watched address that writes any value other than the recorded one closes the pair as a misspeculation. `squash_o` pulses if the pair was elided, and the entry's confidence returns to 0.
- R8: A pair still open in the WINDOW-th cycle after its opening store (WINDOW = 8) is abandoned in that cycle. `squash_o` pulses if the pair was elided, and confidence returns to 0. A restoring store arriving in that same cycle validates instead.
- R9: While a pair is open, a store to another address is neither elided nor tracked. It leaves all outputs low, and the state of its own entry is unchanged.
- R10: A store whose new value equals its old value never opens a pair.
- R11: Confidence saturates at 3, so further validations keep the entry eligible for elision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid_i | input | 1 | A store is presented this cycle |
| st_pc_i | input | 32 | Program counter of the store |
| st_addr_i | input | 32 | Store address |
| st_old_i | input | 32 | Value held at the address before the store |
| st_new_i | input | 32 | Value the store writes |
| lock_held_i | input | 1 | Hint that the location is held by another thread |
| elide_o | output | 1 | Hold back this store; an elided pair is opened |
| commit_o | output | 1 | Elided pair validated; both stores are dropped |
| squash_o | output | 1 | Elided pair failed; the held-back store must be performed |
| pair_tag_o | output | 5 | Table index of the pair concerned by the pulse |

## Verification
The pair-window expiry and the arrival of the restoring store can land in the same cycle. The bench provokes this by opening an elided pair, idling exactly seven cycles and presenting the restoring store in the eighth: it must see `commit_o` and no `squash_o`. A companion run idles eight cycles and must see a single squash carrying that entry's tag, followed by a non-elided store from the same PC. A second overlap is the conflicting write against an open pair, and the table update it causes. It is judged through the next store from that PC, which must no longer be elided.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // Mode of the single pair tracker.
    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_TRAIN = 2'd1,
        TRK_SPEC  = 2'd2
    } trk_mode_e;

    localparam int unsigned SSP_PC_LSB = 2;

endpackage

// File: rtl/ssp_table.sv
module ssp_table #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned CONF_W  = 2,
    parameter int unsigned PC_LSB  = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic [IDX_W-1:0]  lk_idx,
    output logic              lk_hit,
    output logic [CONF_W-1:0] lk_conf,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic              upd_en,
    input  logic              upd_ok,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic [TAG_W-1:0]  upd_tag
);

    localparam int unsigned HI_LSB = PC_LSB + IDX_W + TAG_W;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][CONF_W-1:0] conf;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic upd_hit;

    logic pc_unused;
    assign pc_unused = ^{lk_pc[PC_W-1:HI_LSB], lk_pc[PC_LSB-1:0]};

    always_comb begin
        lk_idx  = lk_pc[PC_LSB +: IDX_W];
        lk_tag  = lk_pc[PC_LSB+IDX_W +: TAG_W];
        lk_hit  = tbl_q.vld[lk_idx] && (tbl_q.tag[lk_idx] == lk_tag);
        lk_conf = tbl_q.conf[lk_idx];
    end

    always_comb begin
        tbl_d   = tbl_q;
        upd_hit = tbl_q.vld[upd_idx] && (tbl_q.tag[upd_idx] == upd_tag);
        if (upd_en) begin
            if (upd_ok) begin
                if (upd_hit) begin
                    if (tbl_q.conf[upd_idx] != {CONF_W{1'b1}}) begin
                        tbl_d.conf[upd_idx] = tbl_q.conf[upd_idx] + 1'b1;
                    end
                end else begin
                    tbl_d.vld[upd_idx]  = 1'b1;
                    tbl_d.tag[upd_idx]  = upd_tag;
                    tbl_d.conf[upd_idx] = CONF_W'(1);
                end
            end else if (upd_hit) begin
                tbl_d.conf[upd_idx] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    AST_CONF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_ok && upd_hit) |=> (tbl_q.conf[$past(upd_idx)] == '0)); // R7

    AST_CONF_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_ok && upd_hit && tbl_q.conf[upd_idx] != '0)
        |=> (tbl_q.conf[$past(upd_idx)] != '0)); // R11

    AST_ALLOC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_ok && !upd_hit) |=> (tbl_q.conf[$past(upd_idx)] == CONF_W'(1))); // R3

endmodule

// File: rtl/ssp_tracker.sv
module ssp_tracker
    import ssp_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned WINDOW = 8,
    localparam int unsigned CNT_W = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_new,
    input  logic              start_en,
    input  logic              start_spec,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_old,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [TAG_W-1:0]  start_tag,
    output logic              busy,
    output logic              res_valid,
    output logic              res_ok,
    output logic              res_spec,
    output logic [IDX_W-1:0]  res_idx,
    output logic [TAG_W-1:0]  res_tag
);

    typedef struct packed {
        trk_mode_e         mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] old;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [CNT_W-1:0]  cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic touch;
    logic expire;

    always_comb begin
        busy      = (trk_q.mode != TRK_IDLE);
        touch     = busy && st_valid && (st_addr == trk_q.addr);
        expire    = busy && (trk_q.cnt == CNT_W'(WINDOW - 1));
        res_valid = touch || expire;
        res_ok    = touch && (st_new == trk_q.old);
        res_spec  = (trk_q.mode == TRK_SPEC);
        res_idx   = trk_q.idx;
        res_tag   = trk_q.tag;

        trk_d = trk_q;
        if (res_valid) begin
            trk_d.mode = TRK_IDLE;
            trk_d.cnt  = '0;
        end else if (busy) begin
            trk_d.cnt = trk_q.cnt + 1'b1;
        end else if (start_en) begin
            trk_d.mode = start_spec ? TRK_SPEC : TRK_TRAIN;
            trk_d.addr = start_addr;
            trk_d.old  = start_old;
            trk_d.idx  = start_idx;
            trk_d.tag  = start_tag;
            trk_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '{mode: TRK_IDLE, default: '0};
        end else begin
            trk_q <= trk_d;
        end
    end

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (trk_q.cnt < CNT_W'(WINDOW))); // R8

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_en |-> (trk_q.mode == TRK_IDLE)); // R9

    AST_OPEN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_en |=> (busy && trk_q.cnt == '0)); // R3

endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
    import ssp_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 32,
    parameter int unsigned TAG_W   = 6,
    parameter int unsigned CONF_W  = 2,
    parameter int unsigned CONF_TH = 2,
    parameter int unsigned WINDOW  = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid_i,
    input  logic [PC_W-1:0]   st_pc_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic [DATA_W-1:0] st_old_i,
    input  logic [DATA_W-1:0] st_new_i,
    input  logic              lock_held_i,
    output logic              elide_o,
    output logic              commit_o,
    output logic              squash_o,
    output logic [IDX_W-1:0]  pair_tag_o
);

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic [CONF_W-1:0] lk_conf;
    logic              busy;
    logic              res_valid, res_ok, res_spec;
    logic [IDX_W-1:0]  res_idx;
    logic [TAG_W-1:0]  res_tag;
    logic              cand, confident, start_spec;

    ssp_table #(
        .PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W),
        .CONF_W(CONF_W), .PC_LSB(SSP_PC_LSB)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_pc   (st_pc_i),
        .lk_idx  (lk_idx),
        .lk_hit  (lk_hit),
        .lk_conf (lk_conf),
        .lk_tag  (lk_tag),
        .upd_en  (res_valid),
        .upd_ok  (res_ok),
        .upd_idx (res_idx),
        .upd_tag (res_tag)
    );

    ssp_tracker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .TAG_W(TAG_W), .WINDOW(WINDOW)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_valid   (st_valid_i),
        .st_addr    (st_addr_i),
        .st_new     (st_new_i),
        .start_en   (cand),
        .start_spec (start_spec),
        .start_addr (st_addr_i),
        .start_old  (st_old_i),
        .start_idx  (lk_idx),
        .start_tag  (lk_tag),
        .busy       (busy),
        .res_valid  (res_valid),
        .res_ok     (res_ok),
        .res_spec   (res_spec),
        .res_idx    (res_idx),
        .res_tag    (res_tag)
    );

    always_comb begin
        cand       = st_valid_i && !busy && (st_new_i != st_old_i);
        confident  = lk_hit && (lk_conf >= CONF_W'(CONF_TH));
        start_spec = cand && confident && !lock_held_i;
        elide_o    = start_spec;
        commit_o   = res_valid && res_ok && res_spec;
        squash_o   = res_valid && !res_ok && res_spec;
        if (res_valid) begin
            pair_tag_o = res_idx;
        end else if (start_spec) begin
            pair_tag_o = lk_idx;
        end else begin
            pair_tag_o = '0;
        end
    end

    AST_HELD_NO_ELIDE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_held_i |-> !elide_o); // R5

    AST_ELIDE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        elide_o |=> busy); // R4

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && squash_o)); // R6

    AST_SILENT_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid_i && st_new_i == st_old_i && !busy) |=> !busy); // R10

endmodule

// File: tb/ssp_predictor_test.sv
`timescale 1ns/1ps
module ssp_predictor_test;

    localparam int WIN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid_i = 1'b0;
    logic [31:0] st_pc_i = '0;
    logic [31:0] st_addr_i = '0;
    logic [31:0] st_old_i = '0;
    logic [31:0] st_new_i = '0;
    logic        lock_held_i = 1'b0;
    logic        elide_o, commit_o, squash_o;
    logic [4:0]  pair_tag_o;

    int checks = 0;
    int failures = 0;
    logic       o_el, o_cm, o_sq;
    logic [4:0] o_tag;
    int sq_seen, cm_seen;
    logic [4:0] sq_tag;

    always #2.5 clk = ~clk;

    ssp_predictor uut (
        .clk(clk), .rst_n(rst_n), .st_valid_i(st_valid_i), .st_pc_i(st_pc_i),
        .st_addr_i(st_addr_i), .st_old_i(st_old_i), .st_new_i(st_new_i),
        .lock_held_i(lock_held_i), .elide_o(elide_o), .commit_o(commit_o),
        .squash_o(squash_o), .pair_tag_o(pair_tag_o)
    );

    function automatic logic [31:0] mk_pc(input int idx, input int tg);
        return (32'(tg & 63) << 7) | (32'(idx & 31) << 2) | 32'h4000_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic store(input logic [31:0] pc, input logic [31:0] addr,
                         input logic [31:0] od, input logic [31:0] nw, input logic held);
        @(negedge clk);
        st_valid_i = 1'b1; st_pc_i = pc; st_addr_i = addr;
        st_old_i = od; st_new_i = nw; lock_held_i = held;
        #1;
        o_el = elide_o; o_cm = commit_o; o_sq = squash_o; o_tag = pair_tag_o;
        @(posedge clk);
        #0.5;
        st_valid_i = 1'b0; lock_held_i = 1'b0;
    endtask

    task automatic idle(input int n);
        sq_seen = 0; cm_seen = 0; sq_tag = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            st_valid_i = 1'b0;
            #1;
            if (squash_o) begin sq_seen++; sq_tag = pair_tag_o; end
            if (commit_o) cm_seen++;
            @(posedge clk);
        end
    endtask

    // Open pair for entry idx; expect elision as given.
    task automatic open_pair(input int idx, input int tg, input logic held,
                             input bit exp_el, input string req);
        store(mk_pc(idx, tg), 32'(200 + idx), 32'(3 * idx), 32'(3 * idx + 1), held);
        chk(o_el == exp_el, req, int'(o_el), int'(exp_el));
        if (exp_el) chk(o_tag == 5'(idx), req, int'(o_tag), idx);
    endtask

    task automatic close_pair(input int idx, input bit exp_cm, input string req);
        store(mk_pc(idx ^ 16, 63), 32'(200 + idx), 32'(3 * idx + 1), 32'(3 * idx), 1'b0);
        chk(o_cm == exp_cm && o_sq == 1'b0, req, int'({o_cm, o_sq}), int'({exp_cm, 1'b0}));
        if (exp_cm) chk(o_tag == 5'(idx), req, int'(o_tag), idx);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk({elide_o, commit_o, squash_o} == 3'b000 && pair_tag_o == '0, "R1",
            int'({elide_o, commit_o, squash_o}), 0);

        // R3 R4 R11: sweep all entries, five rounds each
        for (int idx = 0; idx < 32; idx++) begin
            for (int r = 1; r <= 5; r++) begin
                open_pair(idx, idx ^ 5, 1'b0, r >= 3, (r == 1) ? "R1" : (r == 5) ? "R11" : "R4");
                close_pair(idx, r >= 3, (r >= 3) ? "R6" : "R3");
            end
        end

        // R2: alias with same index, different tag
        store(mk_pc(0, 5 ^ 1), 32'd300, 32'd0, 32'd1, 1'b0);
        chk(o_el == 1'b0, "R2", int'(o_el), 0);
        store(mk_pc(9, 1), 32'd300, 32'd1, 32'd0, 1'b0);
        chk(o_cm == 1'b0, "R2", int'(o_cm), 0);
        open_pair(0, 5, 1'b0, 1'b0, "R2");
        close_pair(0, 1'b0, "R2");

        // R5: lock held blocks elision but training continues
        open_pair(1, 1 ^ 5, 1'b1, 1'b0, "R5");
        close_pair(1, 1'b0, "R5");
        open_pair(1, 1 ^ 5, 1'b0, 1'b1, "R5");
        close_pair(1, 1'b1, "R5");

        // R7: conflicting write squashes and clears confidence
        open_pair(2, 2 ^ 5, 1'b0, 1'b1, "R7");
        store(mk_pc(20, 2), 32'd202, 32'd7, 32'd99, 1'b0);
        chk(o_sq == 1'b1 && o_cm == 1'b0, "R7", int'({o_cm, o_sq}), 1);
        chk(o_tag == 5'd2, "R7", int'(o_tag), 2);
        open_pair(2, 2 ^ 5, 1'b0, 1'b0, "R7");
        close_pair(2, 1'b0, "R7");

        // R9: one pair in flight
        open_pair(3, 3 ^ 5, 1'b0, 1'b1, "R9");
        store(mk_pc(4, 4 ^ 5), 32'd204, 32'd12, 32'd13, 1'b0);
        chk({o_el, o_cm, o_sq} == 3'b000, "R9", int'({o_el, o_cm, o_sq}), 0);
        close_pair(3, 1'b1, "R9");
        open_pair(4, 4 ^ 5, 1'b0, 1'b1, "R9");
        close_pair(4, 1'b1, "R9");

        // R10: store that leaves the value unchanged opens nothing
        store(mk_pc(5, 5 ^ 5), 32'd205, 32'd7, 32'd7, 1'b0);
        chk(o_el == 1'b0, "R10", int'(o_el), 0);
        open_pair(5, 5 ^ 5, 1'b0, 1'b1, "R10");
        close_pair(5, 1'b1, "R10");

        // R8: restoring store in the last window cycle validates
        open_pair(6, 6 ^ 5, 1'b0, 1'b1, "R8");
        idle(WIN - 1);
        chk(sq_seen == 0, "R8", sq_seen, 0);
        close_pair(6, 1'b1, "R8");

        // R8: one cycle later the window expires
        open_pair(7, 7 ^ 5, 1'b0, 1'b1, "R8");
        idle(WIN);
        chk(sq_seen == 1 && cm_seen == 0, "R8", sq_seen, 1);
        chk(sq_tag == 5'd7, "R8", int'(sq_tag), 7);
        open_pair(7, 7 ^ 5, 1'b0, 1'b0, "R8");
        close_pair(7, 1'b0, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule